// File: doc/BRIEF.md
# Timer Pin Capture and GPIO Controller

This block owns the single IO pin of one general purpose timer channel. A 3-bit function field in the mode register chooses what the pin does. As a GPIO it either drives a programmed level (push-pull or open-drain) or is left as an input. In capture mode it watches the pin for a programmed edge and records each hit in sticky status flags. Those flags raise one level interrupt line when the interrupt is enabled.

Software reaches the block through a small 32-bit register port with two word addresses: the mode register and the status register. Reads are combinational. A write takes effect at the next rising clock edge. The pin input is asynchronous and is synchronized inside the block. Its synchronized level is readable in every mode. Waveform generation, the counter and the prescaler live in other blocks.

Top module: `tpc_pin_ctl`

## Requirements
- R1: Address 0 is the mode register and address 1 the status register. After reset both read as zero. Mode bits [2:0] function, [5:4] drive, [8] interrupt enable, [9] open-drain and [17:16] edge select are writable and read back. Every other mode bit reads zero, and any other address reads zero.
- R2: With function 3'd4 (GPIO), drive 2'b10 gives pin_oe_o=1 and pin_o=0, and drive 2'b11 gives pin_oe_o=1 and pin_o=1. Drive 2'b00 or 2'b01 gives pin_oe_o=0. The outputs change in the cycle after the mode write.
- R3: With the open-drain bit set, a high drive level releases the pin (pin_oe_o=0), while a low drive level still drives it (pin_oe_o=1, pin_o=0).
- R4: In any function other than GPIO, including capture (3'd1) and PWM (3'd3), pin_oe_o is 0 whatever the drive and open-drain fields hold.
- R5: Events are recorded only with function 3'd1 (capture). Edge select 2'b01 matches rising edges, 2'b10 falling edges, 2'b11 both edges, and 2'b00 none. A match sets status bit 0. A rising match also sets bit 1, and a falling match also sets bit 2. A match while bit 0 is already set also sets bit 3 (overrun). A pin change applied before clock edge k is recorded at edge k+2.
- R6: Writing the status register clears each flag whose write-data bit is 1 and leaves the others alone. A flag set by an event in the same cycle as its clear stays set.
- R7: irq_o is high whenever the interrupt-enable bit is set and any of status bits [3:0] is set. Clearing the enable masks irq_o without altering the flags.
- R8: Status bit 8 reads the pin level after a two-flop synchronizer, in every mode. A pin change applied before edge k shows after edge k+1. Status bits [7:4] and [31:9] read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register word address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for addr_i |
| pin_i | input | 1 | Pin input level (asynchronous) |
| pin_o | output | 1 | Pin output level |
| pin_oe_o | output | 1 | Pin output enable |
| irq_o | output | 1 | Capture interrupt, level high |

## Verification
The assertions take we_i, addr_i and wdata_i to be known and stable around each rising edge. They also take the status write strobe to be the only source of flag clears. pin_i is allowed to change at any time, because only its synchronized copy reaches the checked state. The stimulus changes every input 2 ns after a rising edge and holds it for the rest of the cycle. It also times one status clear to land on the exact edge where an event is recorded, so the set-wins case is exercised deliberately.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned FLAG_W   = 4;
  localparam int unsigned FN_LSB   = 0;
  localparam int unsigned DRV_LSB  = 4;
  localparam int unsigned IEN_BIT  = 8;
  localparam int unsigned OD_BIT   = 9;
  localparam int unsigned EDGE_LSB = 16;
  localparam int unsigned LVL_BIT  = 8;

  localparam int unsigned F_EVT  = 0;
  localparam int unsigned F_RISE = 1;
  localparam int unsigned F_FALL = 2;
  localparam int unsigned F_OVR  = 3;

  typedef enum logic [2:0] {
    FN_OFF  = 3'd0,
    FN_CAPT = 3'd1,
    FN_OCMP = 3'd2,
    FN_PWM  = 3'd3,
    FN_GPIO = 3'd4
  } pin_fn_e;

  typedef struct packed {
    logic [1:0] edge_sel;
    logic       od;
    logic       irq_en;
    logic [1:0] drv;
    logic [2:0] fn;
  } mode_t;
endpackage

// File: rtl/tpc_sync.sv
module tpc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous sample
  logic [STAGES:0] sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh <= '0;
    else         sh <= {sh[STAGES-1:0], pin_i};
  end

  assign level_o = sh[STAGES-1];
  assign rise_o  = sh[STAGES-1] & ~sh[STAGES];
  assign fall_o  = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/tpc_mode_reg.sv
module tpc_mode_reg
  import tpc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output mode_t             mode_o
);
  mode_t mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
    end else if (wr_i) begin
      mode_q.fn       <= wdata_i[FN_LSB +: 3];
      mode_q.drv      <= wdata_i[DRV_LSB +: 2];
      mode_q.irq_en   <= wdata_i[IEN_BIT];
      mode_q.od       <= wdata_i[OD_BIT];
      mode_q.edge_sel <= wdata_i[EDGE_LSB +: 2];
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/tpc_flags.sv
module tpc_flags
  import tpc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capt_i,
  input  logic [1:0]        edge_sel_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic [FLAG_W-1:0] clr_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic              hit_o
);
  logic [FLAG_W-1:0] flags_q, set_v;
  logic rise_hit, fall_hit, hit;

  assign rise_hit = capt_i & edge_sel_i[0] & rise_i;
  assign fall_hit = capt_i & edge_sel_i[1] & fall_i;
  assign hit      = rise_hit | fall_hit;

  always_comb begin
    set_v         = '0;
    set_v[F_EVT]  = hit;
    set_v[F_RISE] = rise_hit;
    set_v[F_FALL] = fall_hit;
    set_v[F_OVR]  = hit & flags_q[F_EVT];
  end

  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~clr_i) | set_v;
  end

  assign flags_o = flags_q;
  assign hit_o   = hit;
endmodule

// File: rtl/tpc_pin_ctl.sv
module tpc_pin_ctl
  import tpc_pkg::*;
#(
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              pin_i,
  output logic              pin_o,
  output logic              pin_oe_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(1);

  mode_t             mode_q;
  logic              mode_wr, stat_wr;
  logic [FLAG_W-1:0] clr, flags;
  logic              level, rise, fall, hit;
  logic              drive;

  assign mode_wr = we_i && (addr_i == MODE_ADDR);
  assign stat_wr = we_i && (addr_i == STAT_ADDR);
  assign clr     = stat_wr ? wdata_i[FLAG_W-1:0] : '0;

  tpc_mode_reg u_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (mode_wr),
    .wdata_i(wdata_i),
    .mode_o (mode_q)
  );

  tpc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .level_o(level),
    .rise_o (rise),
    .fall_o (fall)
  );

  tpc_flags u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capt_i    (mode_q.fn == FN_CAPT),
    .edge_sel_i(mode_q.edge_sel),
    .rise_i    (rise),
    .fall_i    (fall),
    .clr_i     (clr),
    .flags_o   (flags),
    .hit_o     (hit)
  );

  // pin drives only in GPIO function; open-drain releases a high level
  assign drive    = (mode_q.fn == FN_GPIO) && mode_q.drv[1];
  assign pin_o    = drive && mode_q.drv[0];
  assign pin_oe_o = drive && !(mode_q.od && mode_q.drv[0]);
  assign irq_o    = mode_q.irq_en && (|flags);

  always_comb begin
    rdata_o = '0;
    if (addr_i == MODE_ADDR) begin
      rdata_o[FN_LSB +: 3]   = mode_q.fn;
      rdata_o[DRV_LSB +: 2]  = mode_q.drv;
      rdata_o[IEN_BIT]       = mode_q.irq_en;
      rdata_o[OD_BIT]        = mode_q.od;
      rdata_o[EDGE_LSB +: 2] = mode_q.edge_sel;
    end else if (addr_i == STAT_ADDR) begin
      rdata_o[FLAG_W-1:0] = flags;
      rdata_o[LVL_BIT]    = level;
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;
endmodule

// File: rtl/tpc_pin_ctl_chk.sv
module tpc_pin_ctl_chk
  import tpc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stat_wr_i,
  input logic              mode_wr_i,
  input logic [DATA_W-1:0] wdata_i,
  input mode_t             mode_i,
  input logic [FLAG_W-1:0] flags_i,
  input logic              hit_i,
  input logic              pin_oe_i,
  input logic              irq_i
);
  AST_OE_ONLY_GPIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_oe_i |-> (mode_i.fn == FN_GPIO)); // R4

  AST_OD_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i.od && mode_i.drv == 2'b11) |-> !pin_oe_i); // R3

  AST_NO_FLAG_OUTSIDE_CAPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i.fn != FN_CAPT && flags_i == '0) |=> (flags_i == '0)); // R5

  AST_RISE_NEEDS_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_i[F_RISE]) |-> $past(mode_i.edge_sel[0])); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_i[F_EVT] && !(stat_wr_i && wdata_i[F_EVT])) |=> flags_i[F_EVT]); // R6

  AST_CLR_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr_i && wdata_i[FLAG_W-1:0] == '1 && !hit_i) |=> (flags_i == '0)); // R6

  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && !stat_wr_i && !mode_wr_i) |=> irq_i); // R7
endmodule

bind tpc_pin_ctl tpc_pin_ctl_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .stat_wr_i(stat_wr),
  .mode_wr_i(mode_wr),
  .wdata_i  (wdata_i),
  .mode_i   (mode_q),
  .flags_i  (flags),
  .hit_i    (hit),
  .pin_oe_i (pin_oe_o),
  .irq_i    (irq_o)
);

// File: tb/tpc_pin_ctl_bench.sv
module tpc_pin_ctl_bench;
  logic        clk = 0;
  logic        rst_ni = 0;
  logic        we = 0;
  logic [1:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic        pin = 0;
  logic        pin_o, pin_oe, irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  tpc_pin_ctl u_tpc_pin_ctl (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pin), .pin_o(pin_o), .pin_oe_o(pin_oe), .irq_o(irq)
  );

  // behavioural reference model
  int unsigned m_fn, m_drv, m_edge;
  bit          m_ien, m_od;
  bit [3:0]    m_flags;
  bit          hist[$];

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_fn = 0; m_drv = 0; m_edge = 0; m_ien = 0; m_od = 0; m_flags = 0;
      hist = '{0, 0, 0};
    end else begin
      bit r, f, rh, fh, hit;
      bit [3:0] clr, nf;
      r   = hist[1] && !hist[2];
      f   = !hist[1] && hist[2];
      rh  = (m_fn == 1) && (m_edge % 2 == 1) && r;
      fh  = (m_fn == 1) && (m_edge >= 2) && f;
      hit = rh || fh;
      clr = (we && addr == 1) ? wdata[3:0] : 4'h0;
      nf  = m_flags & ~clr;
      if (hit) nf[0] = 1;
      if (rh) nf[1] = 1;
      if (fh) nf[2] = 1;
      if (hit && m_flags[0]) nf[3] = 1;
      m_flags = nf;
      if (we && addr == 0) begin
        m_fn = wdata[2:0]; m_drv = wdata[5:4]; m_ien = wdata[8];
        m_od = wdata[9]; m_edge = wdata[17:16];
      end
      hist.push_front(pin);
      if (hist.size() > 4) hist = hist[0:3];
    end
  end

  function automatic logic [31:0] exp_rd();
    logic [31:0] v = 0;
    if (addr == 0) v = 32'(m_edge) << 16 | 32'(m_od) << 9 | 32'(m_ien) << 8 |
                       32'(m_drv) << 4 | 32'(m_fn);
    else if (addr == 1) v = 32'(hist[1]) << 8 | 32'(m_flags);
    return v;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare against the model on every cycle
  always @(negedge clk) if (rst_ni && !done) begin
    bit gp, dr;
    gp = (m_fn == 4); dr = gp && (m_drv >= 2);
    chk(addr == 0 ? "R1 mode" : "R5/R6/R8 status", rdata, exp_rd());
    chk("R7 irq", 32'(irq), 32'(m_ien && m_flags != 0));
    chk("R2 pin_o", 32'(pin_o), 32'(dr && m_drv == 3));
    chk("R2/R3/R4 pin_oe", 32'(pin_oe), 32'(dr && !(m_od && m_drv == 3)));
  end

  task automatic tick(); @(posedge clk); #2; endtask
  task automatic wr(logic [1:0] a, logic [31:0] d);
    we = 1; addr = a; wdata = d; tick(); we = 0; wdata = 0;
  endtask
  task automatic look(logic [1:0] a); addr = a; @(negedge clk); endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_ni = 1;
    // R1 reset state
    look(0); chk("R1 reset mode", rdata, 0);
    look(1); chk("R1 reset status", rdata, 0);
    chk("R7 reset irq", 32'(irq), 0);
    // R1 field mask and unmapped address
    wr(0, 32'hFFFF_FFFF); look(0); chk("R1 mask", rdata, 32'h0003_0337);
    look(2); chk("R1 unmapped", rdata, 0);
    // R2 gpio drive
    wr(0, 32'h24); @(negedge clk); chk("R2 low oe", 32'(pin_oe), 1); chk("R2 low", 32'(pin_o), 0);
    wr(0, 32'h34); @(negedge clk); chk("R2 high oe", 32'(pin_oe), 1); chk("R2 high", 32'(pin_o), 1);
    wr(0, 32'h14); @(negedge clk); chk("R2 input", 32'(pin_oe), 0);
    // R3 open drain
    wr(0, 32'h234); @(negedge clk); chk("R3 release", 32'(pin_oe), 0);
    wr(0, 32'h224); @(negedge clk); chk("R3 low", 32'(pin_oe), 1); chk("R3 low lvl", 32'(pin_o), 0);
    // R4 non-gpio functions never drive
    wr(0, 32'h0001_0131); @(negedge clk); chk("R4 capture", 32'(pin_oe), 0);
    wr(0, 32'h33); @(negedge clk); chk("R4 pwm", 32'(pin_oe), 0);
    // R5 rising capture
    wr(0, 32'h0001_0101); pin = 1; repeat (4) tick();
    look(1); chk("R5 rise", rdata, 32'h103); chk("R7 irq on", 32'(irq), 1);
    pin = 0; repeat (4) tick(); look(1); chk("R5 fall ignored", rdata, 32'h003);
    // R6 partial and full clear
    wr(1, 32'h1); look(1); chk("R6 partial", rdata, 32'h002); chk("R7 irq kept", 32'(irq), 1);
    wr(1, 32'hF); look(1); chk("R6 clear all", rdata, 0); chk("R7 irq off", 32'(irq), 0);
    // R5 falling capture and overrun
    wr(0, 32'h0002_0101); pin = 1; repeat (4) tick(); look(1); chk("R5 rise ignored", rdata, 32'h100);
    pin = 0; repeat (4) tick(); look(1); chk("R5 fall", rdata, 32'h005);
    pin = 1; repeat (4) tick(); pin = 0; repeat (4) tick();
    look(1); chk("R5 overrun", rdata, 32'h00D);
    // R7 masking keeps flags
    wr(0, 32'h0002_0001); look(1); chk("R7 masked", 32'(irq), 0); chk("R7 flags kept", rdata, 32'h00D);
    wr(0, 32'h0002_0101); @(negedge clk); chk("R7 unmasked", 32'(irq), 1);
    wr(1, 32'hF);
    // R6 set wins over same-cycle clear
    wr(0, 32'h0003_0101); pin = 1; tick(); tick();
    we = 1; addr = 1; wdata = 32'hF; tick(); we = 0; wdata = 0;
    look(1); chk("R6 set wins", rdata, 32'h103);
    // R5/R8 gpio input: level visible, no flags
    wr(1, 32'hF); wr(0, 32'h4); pin = 0; repeat (4) tick();
    pin = 1; repeat (4) tick(); look(1); chk("R5 no flags in gpio", rdata, 32'h100);
    pin = 0; tick(); look(1); chk("R8 level latency 1", rdata, 32'h100);
    tick(); look(1); chk("R8 level latency 2", rdata, 32'h000);
    wr(0, 32'h0); pin = 1; repeat (3) tick(); look(1); chk("R8 disabled mode", rdata, 32'h100);
    repeat (4) tick();
    finish_run();
  end
endmodule